// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Controller

This block is a byte-wide static memory with a shadow nonvolatile copy of every word. It also contains the control that moves the whole array between the two copies. In normal operation the host port acts as a plain synchronous SRAM: chip enable, output enable, write enable, an address, write data in, read data out, and a drive-enable that marks when read data is valid. When drive-enable is low, the data pins are in their high-impedance state.

A transfer can run in either direction:
- **STORE** copies the working array into the shadow.
- **RECALL** first clears the working array and then loads it from the shadow.

A transfer can be started in several ways:
- A rising edge on the power-fail input starts a STORE.
- A rising edge on power-good starts a RECALL.
- A rising edge on the hardware store request starts a STORE.
- A software unlock sequence of six reads starts either one.

Transfers move one word per clock, and `busy` is high for the whole transfer. While `busy` is high, the host port is locked out.

The host port is not a stream. The block accepts an access on every clock edge at which chip enable is low. There is no ready signal and no back-pressure. Any access that arrives while `busy` is high is dropped.

Top module: `nvs_ctrl`

## Requirements
- R1: An access is sampled at a rising clock edge while `ce_n` is low. A write is when `we_n` is low; the addressed word takes `din`. A read is when `we_n` is high and `oe_n` is low. One cycle after the read edge, `dout` holds the addressed word and `dout_en` is 1.
- R2: A rising edge on `store_req` while idle starts a STORE. `busy` is high for exactly 2^AW cycles, beginning in the cycle after the edge. After the STORE, the shadow equals the working array as it was at the start.
- R3: A rising edge on `pwr_fail` while idle starts a STORE, the same as in R2. A rising edge on `pwr_fail` during a STORE has no effect.
- R4: A rising edge on `pwr_good` while idle starts a RECALL. `busy` is high for exactly 2*2^AW cycles. The first half clears the words in ascending address order. The second half loads each word from the shadow.
- R5: Six consecutive reads at addresses SEQ_0, SEQ_1, SEQ_2, SEQ_3, SEQ_4 and then SEQ_STORE start a STORE. If the last address is SEQ_RECALL instead, they start a RECALL. The transfer begins in the cycle after the sixth read. That sixth read returns no data (`dout_en` stays 0).
- R6: Any of the following aborts the sequence, and the detector starts again from SEQ_0:
  - a write during the sequence;
  - a read at an address that is not the next expected one.

  Cycles with `ce_n` high, and cycles with `ce_n` low but both `oe_n` and `we_n` high, are not accesses. They neither advance nor abort the sequence.
- R7: While `busy` is high, `dout_en` is 0, writes do not change the array, reads produce no data, and reads do not advance the sequence.
- R8: A RECALL never changes the shadow, so repeated RECALLs return the same contents.
- R9: A rising edge on `pwr_fail` during a RECALL abandons it: `busy` is 0 in the next cycle. No STORE follows, so the shadow keeps its last committed contents. Words that were cleared before the abort read as 0.
- R10: During reset and after it, `busy` and `dout_en` are 0.
- R11: When several triggers arrive at the same edge, the winner is chosen in this order: power-fail, power-good, store request, software sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| dout | output | DW | Read data |
| dout_en | output | 1 | Read data driven (0 means high impedance) |
| store_req | input | 1 | Hardware store request, rising edge |
| pwr_fail | input | 1 | Power-fail indication, rising edge |
| pwr_good | input | 1 | Power-good indication, rising edge |
| busy | output | 1 | Transfer in progress |

## Verification
Each wrong internal state shows up at the ports:
- A sequence detector that counts wrongly makes `busy` rise one read too early or too late, or fail to rise at all. This shows in the cycle after the offending read.
- A sweep index that runs short or long changes how long `busy` stays high. This shows on the last cycle of the transfer.
- A phase order that is wrong, or a clear that writes the shadow, appears only on the next read of an affected word. That read returns a value the reference model does not predict.

Because of this delay, every transfer in the bench is followed by reads of words from both ends of the array.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_STORE = 2'd1,
    XF_CLEAR = 2'd2,
    XF_LOAD  = 2'd3
  } xfer_mode_e;

  localparam int unsigned SEQ_LEN = 6;
endpackage

// File: rtl/nvs_seq_detect.sv
module nvs_seq_detect
  import nvs_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter logic [AW-1:0] SEQ_0 = '0,
  parameter logic [AW-1:0] SEQ_1 = '0,
  parameter logic [AW-1:0] SEQ_2 = '0,
  parameter logic [AW-1:0] SEQ_3 = '0,
  parameter logic [AW-1:0] SEQ_4 = '0,
  parameter logic [AW-1:0] SEQ_STORE = '0,
  parameter logic [AW-1:0] SEQ_RECALL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic          rd_acc,
  input  logic          wr_acc,
  input  logic [AW-1:0] addr,
  output logic          sw_store,
  output logic          sw_recall
);
  localparam logic [2:0] TAIL_STEP = 3'(SEQ_LEN - 1);

  logic [2:0] step_q;
  logic       tail;
  logic       hit;

  function automatic logic [AW-1:0] want(input logic [2:0] s);
    case (s)
      3'd0:    return SEQ_0;
      3'd1:    return SEQ_1;
      3'd2:    return SEQ_2;
      3'd3:    return SEQ_3;
      default: return SEQ_4;
    endcase
  endfunction

  assign tail      = (step_q == TAIL_STEP);
  assign hit       = rd_acc && !tail && (addr == want(step_q));
  assign sw_store  = en && rd_acc && tail && (addr == SEQ_STORE);
  assign sw_recall = en && rd_acc && tail && (addr == SEQ_RECALL);

  // R6: any write or unexpected read drops back to the first step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= 3'd0;
    end else if (clr) begin
      step_q <= 3'd0;
    end else if (en && (rd_acc || wr_acc)) begin
      step_q <= hit ? step_q + 3'd1 : 3'd0;
    end
  end
endmodule

// File: rtl/nvs_xfer_seq.sv
module nvs_xfer_seq
  import nvs_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_store,
  input  logic          start_recall,
  input  logic          pf_rise,
  output xfer_mode_e    mode,
  output logic [AW-1:0] idx
);
  localparam logic [AW-1:0] LAST_IDX = '1;

  xfer_mode_e    mode_q;
  logic [AW-1:0] idx_q;
  logic          at_end;

  assign at_end = (idx_q == LAST_IDX);
  assign mode   = mode_q;
  assign idx    = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= XF_IDLE;
      idx_q  <= '0;
    end else begin
      unique case (mode_q)
        XF_IDLE: begin
          idx_q <= '0;
          if (start_store)       mode_q <= XF_STORE;
          else if (start_recall) mode_q <= XF_CLEAR;
        end
        XF_STORE: begin
          idx_q <= idx_q + 1'b1;
          if (at_end) mode_q <= XF_IDLE;
        end
        XF_CLEAR: begin
          idx_q <= idx_q + 1'b1;
          if (pf_rise)     mode_q <= XF_IDLE;
          else if (at_end) mode_q <= XF_LOAD;
        end
        XF_LOAD: begin
          idx_q <= idx_q + 1'b1;
          if (pf_rise || at_end) mode_q <= XF_IDLE;
        end
        default: mode_q <= XF_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays
  import nvs_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  xfer_mode_e    mode,
  input  logic [AW-1:0] idx,
  input  logic          host_we,
  input  logic          host_rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] work_q   [DEPTH];
  logic [DW-1:0] shadow_q [DEPTH];

  always_ff @(posedge clk) begin
    unique case (mode)
      XF_STORE: shadow_q[idx] <= work_q[idx];
      XF_CLEAR: work_q[idx]   <= '0;
      XF_LOAD:  work_q[idx]   <= shadow_q[idx];
      default: begin
        if (host_we) work_q[addr] <= din;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (host_rd) rd_data <= work_q[addr];
  end
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] SEQ_0      = 11'h2A5,
  parameter logic [AW-1:0] SEQ_1      = 11'h5DA,
  parameter logic [AW-1:0] SEQ_2      = 11'h13C,
  parameter logic [AW-1:0] SEQ_3      = 11'h6C3,
  parameter logic [AW-1:0] SEQ_4      = 11'h0F1,
  parameter logic [AW-1:0] SEQ_STORE  = 11'h70E,
  parameter logic [AW-1:0] SEQ_RECALL = 11'h18E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  input  logic          store_req,
  input  logic          pwr_fail,
  input  logic          pwr_good,
  output logic          busy
);
  localparam int unsigned N_EDGE = 3;

  logic [N_EDGE-1:0] lvl, lvl_q, rise;
  logic pf_rise, pg_rise, sr_rise;
  logic rd_acc, wr_acc, idle;
  logic sw_store, sw_recall;
  logic start_store, start_recall;
  logic rd_q;
  xfer_mode_e    xmode;
  logic [AW-1:0] xidx;

  assign lvl = {store_req, pwr_good, pwr_fail};

  for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[g] <= 1'b0;
      else        lvl_q[g] <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~lvl_q[g];
  end

  assign pf_rise = rise[0];
  assign pg_rise = rise[1];
  assign sr_rise = rise[2];

  assign idle   = (xmode == XF_IDLE);
  assign busy   = !idle;
  assign wr_acc = !ce_n && !we_n;
  assign rd_acc = !ce_n && we_n && !oe_n;

  // R11: power-fail > power-good > store request > software sequence
  assign start_store  = idle && (pf_rise || (!pg_rise && (sr_rise || sw_store)));
  assign start_recall = idle && !pf_rise && (pg_rise || (!sr_rise && sw_recall));

  nvs_seq_detect #(
    .AW(AW), .SEQ_0(SEQ_0), .SEQ_1(SEQ_1), .SEQ_2(SEQ_2), .SEQ_3(SEQ_3),
    .SEQ_4(SEQ_4), .SEQ_STORE(SEQ_STORE), .SEQ_RECALL(SEQ_RECALL)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .en(idle), .clr(start_store || start_recall),
    .rd_acc(rd_acc), .wr_acc(wr_acc), .addr(addr),
    .sw_store(sw_store), .sw_recall(sw_recall)
  );

  nvs_xfer_seq #(.AW(AW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .start_store(start_store),
    .start_recall(start_recall), .pf_rise(pf_rise),
    .mode(xmode), .idx(xidx)
  );

  nvs_arrays #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .mode(xmode), .idx(xidx),
    .host_we(idle && wr_acc), .host_rd(idle && rd_acc),
    .addr(addr), .din(din), .rd_data(dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= idle && rd_acc;
  end

  // R7: nothing is driven while a transfer runs
  assign dout_en = rd_q && !busy;
endmodule

// File: rtl/nvs_ctrl_chk.sv
module nvs_ctrl_chk
  import nvs_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          dout_en,
  input logic [DW-1:0] dout,
  input logic          store_req,
  input logic          pwr_fail,
  input xfer_mode_e    mode,
  input logic [AW-1:0] idx
);
  localparam logic [AW-1:0] LAST_IDX = '1;

  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dout_en); // R7
  AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dout)); // R7
  AST_HWSTORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $rose(store_req)) |=> busy); // R2
  AST_STORE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == XF_STORE && idx == LAST_IDX) |=> !busy); // R2
  AST_PFAIL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $rose(pwr_fail)) |=> (mode == XF_STORE)); // R3
  AST_CLEAR_TO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == XF_CLEAR && idx == LAST_IDX && !$rose(pwr_fail)) |=> (mode == XF_LOAD)); // R4
  AST_PF_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == XF_CLEAR || mode == XF_LOAD) && $rose(pwr_fail)) |=> !busy); // R9
endmodule

bind nvs_ctrl nvs_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .dout_en(dout_en), .dout(dout),
  .store_req(store_req), .pwr_fail(pwr_fail), .mode(xmode), .idx(xidx)
);

// File: tb/nvs_ctrl_test.sv
`timescale 1ns/100ps
module nvs_ctrl_test;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] S0 = 6'h15, S1 = 6'h2A, S2 = 6'h0C, S3 = 6'h33,
                            S4 = 6'h07, SST = 6'h38, SRC = 6'h23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic store_req = 1'b0, pwr_fail = 1'b0, pwr_good = 1'b0;
  logic [DW-1:0] dout;
  logic dout_en, busy;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nvs_ctrl #(.AW(AW), .DW(DW), .SEQ_0(S0), .SEQ_1(S1), .SEQ_2(S2), .SEQ_3(S3),
             .SEQ_4(S4), .SEQ_STORE(SST), .SEQ_RECALL(SRC)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .store_req(store_req), .pwr_fail(pwr_fail), .pwr_good(pwr_good), .busy(busy)
  );

  // behavioural reference: 0 idle, 1 store, 2 clear, 3 load
  int m_mode = 0, m_idx = 0, m_step = 0;
  bit m_rdq = 0, pfq = 0, pgq = 0, srq = 0;
  logic [DW-1:0] m_dout = '0;
  logic [DW-1:0] m_work [DEPTH];
  logic [DW-1:0] m_shadow [DEPTH];
  logic [AW-1:0] seq_q [$] = '{S0, S1, S2, S3, S4};

  always @(posedge clk) begin
    bit pfr, pgr, srr, rd, wr, swst, swrc;
    if (!rst_n) begin
      m_mode = 0; m_idx = 0; m_step = 0; m_rdq = 0; pfq = 0; pgq = 0; srq = 0;
    end else begin
      pfr = pwr_fail && !pfq; pgr = pwr_good && !pgq; srr = store_req && !srq;
      rd = !ce_n && we_n && !oe_n; wr = !ce_n && !we_n;
      swst = 0; swrc = 0;
      if (m_mode == 0) begin
        m_rdq = rd;
        if (rd) m_dout = m_work[addr];
        if (wr) m_work[addr] = din;
        if (wr) m_step = 0;
        else if (rd) begin
          if (m_step < 5) m_step = (addr == seq_q[m_step]) ? m_step + 1 : 0;
          else begin
            swst = (addr == SST); swrc = (addr == SRC); m_step = 0;
          end
        end
        if (pfr || (!pgr && (srr || swst))) begin m_mode = 1; m_idx = 0; m_step = 0; end
        else if (pgr || swrc) begin m_mode = 2; m_idx = 0; m_step = 0; end
      end else begin
        m_rdq = 0;
        case (m_mode)
          1: begin m_shadow[m_idx] = m_work[m_idx]; if (m_idx == DEPTH-1) m_mode = 0; end
          2: begin m_work[m_idx] = '0;
                   if (pfr) m_mode = 0; else if (m_idx == DEPTH-1) m_mode = 3; end
          default: begin m_work[m_idx] = m_shadow[m_idx];
                   if (pfr || m_idx == DEPTH-1) m_mode = 0; end
        endcase
        m_idx = (m_idx + 1) % DEPTH;
      end
      pfq = pwr_fail; pgq = pwr_good; srq = store_req;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!done) begin
      chk("R2 busy", int'(busy), int'(m_mode != 0));
      chk("R7 dout_en", int'(dout_en), int'(m_rdq && m_mode == 0));
      if (dout_en && m_rdq) chk("R1 dout", int'(dout), int'(m_dout));
    end
  end

  function automatic logic [DW-1:0] pat(input int i, input int s);
    return DW'(i * s + 17 * s + i + 1);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce_n = 0; we_n = 0; oe_n = 1; addr = a; din = d;
    @(negedge clk);
    ce_n = 1; we_n = 1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic en);
    ce_n = 0; we_n = 1; oe_n = 0; addr = a;
    @(negedge clk);
    ce_n = 1; oe_n = 1;
    d = dout; en = dout_en;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] d; logic en;
    rd(a, d, en);
    chk(req, int'(en), 1);
    chk(req, int'(d), int'(exp));
  endtask

  task automatic fill(input int s);
    for (int i = 0; i < DEPTH; i++) wr(AW'(i), pat(i, s));
  endtask

  task automatic measure(input string req, input int exp);
    int n = 0;
    while (busy && n < 400) begin n++; @(negedge clk); end
    chk(req, n, exp);
  endtask

  task automatic pulse_sr();
    store_req = 1; @(negedge clk); store_req = 0;
  endtask

  task automatic pulse_pg();
    pwr_good = 0; @(negedge clk); pwr_good = 1; @(negedge clk);
  endtask

  task automatic seq(input logic [AW-1:0] last, output logic en);
    logic [DW-1:0] d;
    rd(S0, d, en); rd(S1, d, en); rd(S2, d, en); rd(S3, d, en); rd(S4, d, en);
    rd(last, d, en);
  endtask

  initial begin
    logic en; logic [DW-1:0] d;
    @(negedge clk); @(negedge clk);
    chk("R10 busy in reset", int'(busy), 0);
    chk("R10 dout_en in reset", int'(dout_en), 0);
    rst_n = 1; @(negedge clk);
    chk("R10 busy after reset", int'(busy), 0);

    fill(3);
    rd_chk("R1 readback", 6'd9, pat(9, 3));
    pulse_sr(); measure("R2 store length", DEPTH);

    fill(5); pulse_sr();
    wr(6'd5, 8'hEE);
    rd(6'd6, d, en); chk("R7 read during busy", int'(en), 0);
    measure("R2 store length", DEPTH - 2);
    rd_chk("R7 write ignored", 6'd5, pat(5, 5));

    fill(7); pulse_pg(); measure("R4 recall length", 2 * DEPTH);
    rd_chk("R4 recalled word", 6'd10, pat(10, 5));
    rd_chk("R4 recalled top word", 6'd63, pat(63, 5));
    wr(6'd3, 8'h5A); pulse_pg(); measure("R8 recall length", 2 * DEPTH);
    rd_chk("R8 shadow unchanged", 6'd3, pat(3, 5));

    fill(9); seq(SST, en);
    chk("R5 trigger read silent", int'(en), 0);
    measure("R5 sw store length", DEPTH);
    fill(11); seq(SRC, en); measure("R5 sw recall length", 2 * DEPTH);
    rd_chk("R5 sw recall data", 6'd20, pat(20, 9));

    rd(S0, d, en); rd(S1, d, en); rd(S2, d, en); wr(6'd1, 8'h11);
    rd(S3, d, en); rd(S4, d, en); rd(SST, d, en);
    chk("R6 write aborts", int'(busy), 0);
    rd(S0, d, en); rd(S1, d, en); rd(6'd0, d, en);
    rd(S2, d, en); rd(S3, d, en); rd(S4, d, en); rd(SST, d, en);
    chk("R6 wrong read aborts", int'(busy), 0);
    rd(S0, d, en); rd(S1, d, en); rd(S2, d, en);
    ce_n = 0; we_n = 1; oe_n = 1; @(negedge clk); ce_n = 1; @(negedge clk);
    rd(S3, d, en); rd(S4, d, en); rd(SST, d, en);
    chk("R6 non-access ignored", int'(busy), 1);
    measure("R6 store length", DEPTH);

    fill(13); pwr_fail = 1; @(negedge clk); pwr_fail = 0;
    measure("R3 pf store length", DEPTH);
    fill(15); pulse_pg(); measure("R3 recall length", 2 * DEPTH);
    rd_chk("R3 stored on power fail", 6'd30, pat(30, 13));

    fill(17); pulse_pg();
    repeat (10) @(negedge clk);
    pwr_fail = 1; @(negedge clk);
    chk("R9 recall abandoned", int'(busy), 0);
    pwr_fail = 0;
    rd_chk("R9 cleared word", 6'd0, 8'h00);
    rd_chk("R9 untouched word", 6'd63, pat(63, 17));
    pulse_pg(); measure("R9 recall length", 2 * DEPTH);
    rd_chk("R9 shadow kept", 6'd40, pat(40, 13));

    pwr_good = 0; @(negedge clk);
    pwr_good = 1; pwr_fail = 1; @(negedge clk);
    pwr_fail = 0;
    measure("R11 power fail wins", DEPTH);
    repeat (3) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule